// File: doc/BRIEF.md
# Transmit Link Fault Collector and Reinitialization Sequencer

This block gathers fault events from a serial transmit link into sticky status bits, raises a single interrupt line for any status bit whose interrupt enable is set, and sequences link reinitialization. Four faults are judged from raw signals: a lane PLL lock that falls while the link is running, and three valid drops on the command, transport-data and link-data paths, each seen while that path's ready is high. Three more faults (gearbox overflow, gearbox underflow, SYSREF period mismatch) arrive as one-cycle pulses.

Software reaches four words through a 2-bit address register port: status (write-1-to-clear), interrupt enables, reinit enables and a control word holding a write-1-to-set manual reinit bit. A reinit is launched by the manual bit or by a fresh fault on a bit whose reinit enable is set. The sequencer has three named states: IDLE (waiting, moves to LAUNCH on any trigger), LAUNCH (one cycle: pulses the request, clears the manual bit, always moves to WAIT) and WAIT (holds the busy flag, returns to IDLE after HOLD_CYCLES cycles or as soon as the done input is seen).

Top module: `lnk_err_ctrl`

## Requirements
- R1: Status bit 4 sets one cycle after any lane of `pll_lock_i` goes from 1 to 0 while `link_up_i` is high; a fall with `link_up_i` low leaves it clear.
- R2: Status bit 3 (command), bit 2 (transport data) and bit 1 (link data) set one cycle after a cycle in which that path's ready is 1 and its valid is 0; valid low with ready low has no effect.
- R3: Pulses on `gb_ovf_i`, `gb_udf_i` and `sysref_err_i` set status bits 8, 7 and 0 respectively on the next clock.
- R4: Status (address 0) is sticky; a write to address 0 clears exactly the bits written as 1 and leaves the others set.
- R5: When a fault event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends set.
- R6: `irq_o` is 1 exactly when some status bit and the matching interrupt enable (address 1) are both 1; interrupt enables reset to 0x191 and only bits 8, 7 and 4 to 0 are stored (a write of 0x1FF reads back 0x19F).
- R7: Reinit enables (address 2, bits 3 to 0, matching status bits 3 to 0) reset to 0; a fault on a bit whose reinit enable is 0 starts no reinit.
- R8: In IDLE, a fault event on a bit with its reinit enable set moves the sequencer to LAUNCH at the next clock, where `reinit_req_o` is 1 for exactly one cycle.
- R9: Writing 1 to bit 0 of address 3 sets the manual reinit bit (read back at bit 0 of address 3); it starts a reinit and is cleared when LAUNCH is left.
- R10: `reinit_busy_o` (also bit 1 of address 3) is high in LAUNCH and WAIT: 1 + HOLD_CYCLES cycles in all, or less when `reinit_done_i` is seen in WAIT, which returns to IDLE at the next clock.
- R11: Automatic triggers arriving while busy start no further reinit.
- R12: After reset the status word is 0 and `irq_o`, `reinit_req_o` and `reinit_busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Link is running |
| pll_lock_i | input | LANES | Per-lane PLL lock |
| cmd_ready_i | input | 1 | Command ready from link layer |
| cmd_valid_i | input | 1 | Command valid from upstream |
| tl_ready_i | input | 1 | Transport-data ready |
| tl_valid_i | input | 1 | Transport-data valid |
| ll_ready_i | input | 1 | Link-data ready |
| ll_valid_i | input | 1 | Link-data valid |
| gb_ovf_i | input | 1 | Gearbox overflow pulse |
| gb_udf_i | input | 1 | Gearbox underflow pulse |
| sysref_err_i | input | 1 | SYSREF period mismatch pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 9 | Register write data |
| reg_rdata_o | output | 9 | Register read data for reg_addr_i |
| reinit_done_i | input | 1 | Early end of reinitialization |
| irq_o | output | 1 | Interrupt |
| reinit_req_o | output | 1 | One-cycle reinit request |
| reinit_busy_o | output | 1 | Reinit in progress |

## Verification
The assertions assume the fault pulses are single cycles and that software never sets the manual bit during LAUNCH, so a launched request is always followed by the manual bit clearing. The stimulus drives every input at the falling edge, keeps the manual write away from active reinits, and returns each path to ready-low, valid-high and all lanes locked between vectors so that each fault is provoked exactly once.

// File: rtl/lnk_err_pkg.sv
package lnk_err_pkg;
    localparam int ERR_W = 9;
    localparam int REN_W = 4;
    localparam logic [ERR_W-1:0] ERR_MASK = 9'h19F;
    localparam logic [ERR_W-1:0] IEN_RST  = 9'h191;

    localparam int B_SREF = 0;
    localparam int B_LNK  = 1;
    localparam int B_FRM  = 2;
    localparam int B_CMD  = 3;
    localparam int B_PLL  = 4;
    localparam int B_UDF  = 7;
    localparam int B_OVF  = 8;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_IEN    = 2'd1,
        A_REN    = 2'd2,
        A_CTRL   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lnk_err_detect.sv
module lnk_err_detect
    import lnk_err_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up_i,
    input  logic [LANES-1:0] pll_lock_i,
    input  logic             cmd_ready_i,
    input  logic             cmd_valid_i,
    input  logic             tl_ready_i,
    input  logic             tl_valid_i,
    input  logic             ll_ready_i,
    input  logic             ll_valid_i,
    input  logic             gb_ovf_i,
    input  logic             gb_udf_i,
    input  logic             sysref_err_i,
    output logic [ERR_W-1:0] ev_o
);
    logic [LANES-1:0] lock_q;
    logic [LANES-1:0] lane_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= pll_lock_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_fall[g] = lock_q[g] & ~pll_lock_i[g];
    end

    always_comb begin
        ev_o         = '0;
        ev_o[B_PLL]  = link_up_i & (|lane_fall);
        ev_o[B_CMD]  = cmd_ready_i & ~cmd_valid_i;
        ev_o[B_FRM]  = tl_ready_i & ~tl_valid_i;
        ev_o[B_LNK]  = ll_ready_i & ~ll_valid_i;
        ev_o[B_OVF]  = gb_ovf_i;
        ev_o[B_UDF]  = gb_udf_i;
        ev_o[B_SREF] = sysref_err_i;
    end
endmodule

// File: rtl/lnk_err_regs.sv
module lnk_err_regs
    import lnk_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] ev_i,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [ERR_W-1:0] wdata_i,
    input  logic             man_clr_i,
    output logic [ERR_W-1:0] sts_o,
    output logic [ERR_W-1:0] ien_o,
    output logic [REN_W-1:0] ren_o,
    output logic             man_o
);
    logic [ERR_W-1:0] clr_w;
    logic [ERR_W-1:0] keep_w;
    logic             man_set_w;

    assign clr_w     = (wr_i && addr_i == A_STATUS) ? (wdata_i & ERR_MASK) : '0;
    assign keep_w    = sts_o & ~clr_w;
    assign man_set_w = wr_i && addr_i == A_CTRL && wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_o <= '0;
            ien_o <= IEN_RST;
            ren_o <= '0;
            man_o <= 1'b0;
        end else begin
            sts_o <= (keep_w | ev_i) & ERR_MASK;
            if (wr_i && addr_i == A_IEN) ien_o <= wdata_i & ERR_MASK;
            if (wr_i && addr_i == A_REN) ren_o <= wdata_i[REN_W-1:0];
            if (man_set_w)      man_o <= 1'b1;
            else if (man_clr_i) man_o <= 1'b0;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & $past(keep_w)) == $past(keep_w))); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & $past(ev_i & ERR_MASK)) == $past(ev_i & ERR_MASK))); // R5
    AST_MAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (man_clr_i && !man_set_w) |=> !man_o); // R9
endmodule

// File: rtl/lnk_reinit_seq.sv
module lnk_reinit_seq
    import lnk_err_pkg::*;
#(
    parameter int HOLD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic done_i,
    output logic req_o,
    output logic busy_o,
    output logic launch_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (st_q == ST_WAIT) cnt_q <= cnt_q + 1'b1;
        else                     cnt_q <= '0;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (trig_i) st_d = ST_LAUNCH;
            ST_LAUNCH: st_d = ST_WAIT;
            ST_WAIT:   if (done_i || cnt_q == LAST) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o    = 1'b0;
        busy_o   = 1'b0;
        launch_o = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin
                req_o    = 1'b1;
                busy_o   = 1'b1;
                launch_o = 1'b1;
            end
            ST_WAIT:   busy_o = 1'b1;
            default:   ;
        endcase
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o); // R8
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> (cnt_q < CW'(HOLD_CYCLES))); // R10
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && done_i) |=> !busy_o); // R10
endmodule

// File: rtl/lnk_err_ctrl.sv
module lnk_err_ctrl
    import lnk_err_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int HOLD_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up_i,
    input  logic [LANES-1:0] pll_lock_i,
    input  logic             cmd_ready_i,
    input  logic             cmd_valid_i,
    input  logic             tl_ready_i,
    input  logic             tl_valid_i,
    input  logic             ll_ready_i,
    input  logic             ll_valid_i,
    input  logic             gb_ovf_i,
    input  logic             gb_udf_i,
    input  logic             sysref_err_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [8:0]       reg_wdata_i,
    output logic [8:0]       reg_rdata_o,
    input  logic             reinit_done_i,
    output logic             irq_o,
    output logic             reinit_req_o,
    output logic             reinit_busy_o
);
    logic [ERR_W-1:0] ev_w, sts_w, ien_w;
    logic [REN_W-1:0] ren_w;
    logic man_w, launch_w, trig_w;

    lnk_err_detect #(.LANES(LANES)) u_detect (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .pll_lock_i(pll_lock_i),
        .cmd_ready_i(cmd_ready_i), .cmd_valid_i(cmd_valid_i),
        .tl_ready_i(tl_ready_i), .tl_valid_i(tl_valid_i),
        .ll_ready_i(ll_ready_i), .ll_valid_i(ll_valid_i),
        .gb_ovf_i(gb_ovf_i), .gb_udf_i(gb_udf_i), .sysref_err_i(sysref_err_i),
        .ev_o(ev_w)
    );

    lnk_err_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_w), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .man_clr_i(launch_w), .sts_o(sts_w), .ien_o(ien_w),
        .ren_o(ren_w), .man_o(man_w)
    );

    assign trig_w = man_w | (|(ev_w[REN_W-1:0] & ren_w));

    lnk_reinit_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_w), .done_i(reinit_done_i),
        .req_o(reinit_req_o), .busy_o(reinit_busy_o), .launch_o(launch_w)
    );

    assign irq_o = |(sts_w & ien_w);

    always_comb begin
        unique case (reg_addr_i)
            A_STATUS: reg_rdata_o = sts_w;
            A_IEN:    reg_rdata_o = ien_w;
            A_REN:    reg_rdata_o = {{(ERR_W-REN_W){1'b0}}, ren_w};
            A_CTRL:   reg_rdata_o = {{(ERR_W-2){1'b0}}, reinit_busy_o, man_w};
            default:  reg_rdata_o = '0;
        endcase
    end

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req_o |-> reinit_busy_o); // R10
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sts_w != '0)); // R6
endmodule

// File: tb/lnk_err_ctrl_bench.sv
`timescale 1ns/1ps
module lnk_err_ctrl_bench;
    localparam int LANES = 2;
    localparam int HOLD  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_up, cmd_r, cmd_v, tl_r, tl_v, ll_r, ll_v, ovf, udf, sref;
    logic [LANES-1:0] lock;
    logic wr, done;
    logic [1:0] addr;
    logic [8:0] wdata, rdata;
    logic irq, req, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lnk_err_ctrl #(.LANES(LANES), .HOLD_CYCLES(HOLD)) u_lnk_err_ctrl (
        .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .pll_lock_i(lock),
        .cmd_ready_i(cmd_r), .cmd_valid_i(cmd_v), .tl_ready_i(tl_r), .tl_valid_i(tl_v),
        .ll_ready_i(ll_r), .ll_valid_i(ll_v), .gb_ovf_i(ovf), .gb_udf_i(udf),
        .sysref_err_i(sref), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .reinit_done_i(done), .irq_o(irq),
        .reinit_req_o(req), .reinit_busy_o(busy)
    );

    // {link_up, lock[1:0], cmd_r, cmd_v, tl_r, tl_v, ll_r, ll_v, ovf, udf, sref} , expected status
    localparam logic [20:0] TBL [10] = '{
        {12'b1_11_00_00_00_000, 9'h000},
        {12'b1_10_00_00_00_000, 9'h010},
        {12'b0_00_00_00_00_000, 9'h000},
        {12'b1_11_10_00_00_000, 9'h008},
        {12'b1_11_11_00_00_000, 9'h000},
        {12'b1_11_00_10_00_000, 9'h004},
        {12'b1_11_00_01_10_000, 9'h002},
        {12'b1_11_00_00_00_111, 9'h181},
        {12'b1_01_00_00_00_000, 9'h010},
        {12'b1_11_10_10_10_000, 9'h00E}
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        link_up = 1'b1; lock = '1;
        cmd_r = 1'b0; cmd_v = 1'b1; tl_r = 1'b0; tl_v = 1'b1; ll_r = 1'b0; ll_v = 1'b1;
        ovf = 1'b0; udf = 1'b0; sref = 1'b0;
    endtask

    task automatic apply(input logic [11:0] v);
        {link_up, lock, cmd_r, cmd_v, tl_r, tl_v, ll_r, ll_v, ovf, udf, sref} = v;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [8:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [8:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] rv;
        int nb, nr;
        idle(); wr = 1'b0; addr = 2'd0; wdata = '0; done = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R12 reset state, R6/R7 enable defaults
        rreg(2'd0, rv); chk("R12 status after reset", rv, 9'h000);
        chk("R12 outputs after reset", {6'd0, irq, req, busy}, 9'h000);
        rreg(2'd1, rv); chk("R6 ien reset", rv, 9'h191);
        rreg(2'd2, rv); chk("R7 ren reset", rv, 9'h000);

        // R1 R2 R3 table walk
        for (int i = 0; i < 10; i++) begin
            wreg(2'd0, 9'h1FF);
            apply(TBL[i][20:9]);
            cyc();
            idle();
            rreg(2'd0, rv);
            chk($sformatf("R1/R2/R3 vector %0d", i), rv, TBL[i][8:0]);
            chk($sformatf("R7 no reinit vector %0d", i), {8'd0, busy}, 9'h000);
        end

        // R6 interrupt follows enables
        wreg(2'd0, 9'h1FF);
        cmd_r = 1'b1; cmd_v = 1'b0; cyc(); idle();
        chk("R6 irq off for disabled bit", {8'd0, irq}, 9'h000);
        wreg(2'd1, 9'h199);
        chk("R6 irq on after enable", {8'd0, irq}, 9'h001);
        wreg(2'd1, 9'h1FF);
        rreg(2'd1, rv); chk("R6 ien mask", rv, 9'h19F);
        wreg(2'd1, 9'h191);

        // R4 partial clear
        wreg(2'd0, 9'h1FF);
        tl_r = 1'b1; tl_v = 1'b0; ll_r = 1'b1; ll_v = 1'b0; cyc(); idle();
        wreg(2'd0, 9'h002);
        rreg(2'd0, rv); chk("R4 partial clear", rv, 9'h004);

        // R5 event beats clear
        wr = 1'b1; addr = 2'd0; wdata = 9'h004; tl_r = 1'b1; tl_v = 1'b0;
        cyc(); wr = 1'b0; idle();
        rreg(2'd0, rv); chk("R5 event wins", rv, 9'h004);

        // R9 manual reinit
        wreg(2'd3, 9'h001);
        rreg(2'd3, rv); chk("R9 manual bit set", rv, 9'h001);
        cyc();
        rreg(2'd3, rv); chk("R9 launch busy", rv, 9'h003);
        chk("R8 req in launch", {8'd0, req}, 9'h001);
        cyc();
        rreg(2'd3, rv); chk("R9 manual cleared", rv, 9'h002);
        repeat (HOLD + 2) cyc();

        // R10 early done
        wreg(2'd3, 9'h001);
        cyc(); cyc();
        done = 1'b1; cyc(); done = 1'b0;
        chk("R10 done ends busy", {8'd0, busy}, 9'h000);
        cyc();

        // R8 R10 auto reinit length
        wreg(2'd2, 9'h002);
        rreg(2'd2, rv); chk("R7 ren write", rv, 9'h002);
        ll_r = 1'b1; ll_v = 1'b0; cyc(); idle();
        nb = 0; nr = 0;
        for (int k = 0; k < 50 && busy; k++) begin
            nb++;
            if (req) nr++;
            cyc();
        end
        chk("R10 busy length", 9'(nb), 9'(HOLD + 1));
        chk("R8 single request", 9'(nr), 9'd1);

        // R11 trigger during busy ignored
        ll_r = 1'b1; ll_v = 1'b0; cyc(); idle();
        cyc();
        ll_r = 1'b1; ll_v = 1'b0; cyc(); idle();
        for (int k = 0; k < 50 && busy; k++) cyc();
        cyc();
        chk("R11 no relaunch", {7'd0, req, busy}, 9'h000);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule